// File: doc/BRIEF.md
# Power-Line Frame Builder and Checker

This block turns a set of parallel message fields into a fixed 40-bit serial frame and checks frames of the same shape on the way in. On the transmit side, a one-cycle send strobe captures an 8-bit node address, a direction flag, a resend-request flag, four control bits, five telemetry flags and a 12-bit temperature. The block then adds a two-bit start pattern, a six-bit ones-count checksum and a stop bit. The resulting frame leaves least significant bit first, one bit per valid/ready handshake, toward a modulator that lies outside this block.

On the receive side, the block hunts the incoming bit stream for the start pattern and collects the rest of the frame. It then recounts the ones in the message region. A frame with a matching checksum and a clear stop bit updates the parsed outputs and gives a one-cycle accept pulse. A checksum mismatch gives a reject pulse and raises a standing resend request, which the next good frame clears. A frame whose stop bit is set is rejected without touching the resend request.

Top module: `pl_frame_codec`

## Requirements
- R1: While reset is held, tx_busy and tx_bit_valid are 0, rx_ok, rx_bad and rx_resend are 0, and every parsed output is 0.
- R2: The transmitted frame is sent from bit 0 upward with this layout:
  - bits 0 and 1 are 1;
  - bit 2 is the direction flag;
  - bits 3 to 10 are the node address;
  - bit 11 is the error/resend flag;
  - bits 12 to 15 are the control bits;
  - bits 16 to 20 are the telemetry flags;
  - bits 21 to 32 are the temperature;
  - bit 39, the stop bit, is 0.
  Each field is placed with its least significant bit at the lowest frame position.
- R3: Bits 33 to 38 carry, least significant bit at 33, the number of 1 bits in frame bits 2 to 32. The value ranges from 0 to 31.
- R4: One frame bit is transferred in each cycle where tx_bit_valid and tx_bit_ready are both high. While tx_bit_ready is low, tx_bit_valid stays high and tx_bit holds its value.
- R5: A send strobe is accepted only while tx_busy is low. Strobes while busy are ignored, including one in the same cycle as the final handshake, and they neither change the bits sent nor start another frame.
- R6: tx_busy is high from the cycle after an accepted strobe until the 40th handshake. A strobe after that is accepted again.
- R7: While hunting, two consecutive received 1 bits start a frame, and the next 38 valid bits complete it. If the stop bit is 0 and the checksum matches, the parsed outputs take the frame fields and rx_ok is high for exactly the one cycle after the final bit.
- R8: On a checksum mismatch with a 0 stop bit, rx_bad pulses for one cycle, rx_resend becomes 1, and the parsed outputs keep their previous values.
- R9: A frame whose stop bit is 1 is rejected: rx_bad pulses, rx_resend and the parsed outputs are unchanged, and the receiver returns to hunting, so that a following good frame is accepted.
- R10: While hunting, bits before the first pair of consecutive 1s are ignored and produce no pulse. A good frame clears rx_resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_send | input | 1 | Send strobe for the parallel fields |
| tx_node | input | 8 | Node address to send |
| tx_dir | input | 1 | Direction flag to send |
| tx_err | input | 1 | Error/resend flag to send |
| tx_ctrl | input | 4 | Control bits to send |
| tx_tlm | input | 5 | Telemetry flags to send |
| tx_temp | input | 12 | Temperature value to send |
| tx_busy | output | 1 | Frame being shifted out |
| tx_bit | output | 1 | Current serial bit |
| tx_bit_valid | output | 1 | tx_bit is valid |
| tx_bit_ready | input | 1 | Consumer takes tx_bit this cycle |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_valid | input | 1 | rx_bit is valid this cycle |
| rx_node | output | 8 | Parsed node address |
| rx_dir | output | 1 | Parsed direction flag |
| rx_err | output | 1 | Parsed error/resend flag |
| rx_ctrl | output | 4 | Parsed control bits |
| rx_tlm | output | 5 | Parsed telemetry flags |
| rx_temp | output | 12 | Parsed temperature |
| rx_ok | output | 1 | One-cycle pulse: frame accepted |
| rx_bad | output | 1 | One-cycle pulse: frame rejected |
| rx_resend | output | 1 | Resend request after a checksum mismatch |

## Verification
The transmitter's last handshake and the receiver's frame completion fall on the same clock edge when the serial output is looped back into the input. In that setup, a send strobe held high during the shifting is also present on that edge. The bench provokes this by keeping tx_send asserted with different fields until tx_busy is seen low, with stalls on tx_bit_ready. It judges the result on three points: the looped frame must be accepted with the original fields, tx_busy must stay low afterwards, and no extra bit or frame may appear in the scoreboard.

// File: rtl/pl_frame_codec.sv
module pl_frame_codec #(
  parameter int FRAME_W = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_send,
  input  logic [7:0]  tx_node,
  input  logic        tx_dir,
  input  logic        tx_err,
  input  logic [3:0]  tx_ctrl,
  input  logic [4:0]  tx_tlm,
  input  logic [11:0] tx_temp,
  output logic        tx_busy,
  output logic        tx_bit,
  output logic        tx_bit_valid,
  input  logic        tx_bit_ready,
  input  logic        rx_bit,
  input  logic        rx_bit_valid,
  output logic [7:0]  rx_node,
  output logic        rx_dir,
  output logic        rx_err,
  output logic [3:0]  rx_ctrl,
  output logic [4:0]  rx_tlm,
  output logic [11:0] rx_temp,
  output logic        rx_ok,
  output logic        rx_bad,
  output logic        rx_resend
);
  localparam int CW    = $clog2(FRAME_W + 1);
  localparam int BODY  = 31;
  localparam int SUM_W = 6;
  localparam int LAST  = FRAME_W - 1;

  function automatic logic [SUM_W-1:0] ones(input logic [BODY-1:0] v);
    logic [SUM_W-1:0] n;
    n = '0;
    for (int i = 0; i < BODY; i++) n = n + SUM_W'(v[i]);
    return n;
  endfunction

  logic [BODY-1:0]    tx_body;
  logic [FRAME_W-1:0] tx_frame, tx_sr;
  logic [CW-1:0]      tx_left;

  assign tx_body  = {tx_temp, tx_tlm, tx_ctrl, tx_err, tx_node, tx_dir};
  assign tx_frame = {1'b0, ones(tx_body), tx_body, 2'b11};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      tx_left <= '0;
      tx_busy <= 1'b0;
    end else if (!tx_busy) begin
      if (tx_send) begin
        tx_sr   <= tx_frame;
        tx_left <= CW'(FRAME_W);
        tx_busy <= 1'b1;
      end
    end else if (tx_bit_ready) begin
      tx_sr   <= {1'b0, tx_sr[FRAME_W-1:1]};
      tx_left <= tx_left - 1'b1;
      if (tx_left == CW'(1)) tx_busy <= 1'b0;
    end
  end

  assign tx_bit       = tx_sr[0];
  assign tx_bit_valid = tx_busy;

  logic [LAST-1:2] rx_buf;
  logic [CW-1:0]   rx_cnt;
  logic            rx_prev;
  logic            rx_sum_ok;

  assign rx_sum_ok = ones(rx_buf[32:2]) == rx_buf[LAST-1:33];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf    <= '0;
      rx_cnt    <= '0;
      rx_prev   <= 1'b0;
      rx_ok     <= 1'b0;
      rx_bad    <= 1'b0;
      rx_resend <= 1'b0;
      {rx_temp, rx_tlm, rx_ctrl, rx_err, rx_node, rx_dir} <= '0;
    end else begin
      rx_ok  <= 1'b0;
      rx_bad <= 1'b0;
      if (rx_bit_valid) begin
        if (rx_cnt == '0) begin
          if (rx_prev && rx_bit) begin
            rx_cnt  <= CW'(2);
            rx_prev <= 1'b0;
          end else begin
            rx_prev <= rx_bit;
          end
        end else if (rx_cnt == CW'(LAST)) begin
          rx_cnt <= '0;
          if (rx_bit) begin
            rx_bad <= 1'b1;
          end else if (!rx_sum_ok) begin
            rx_bad    <= 1'b1;
            rx_resend <= 1'b1;
          end else begin
            {rx_temp, rx_tlm, rx_ctrl, rx_err, rx_node, rx_dir} <= rx_buf[32:2];
            rx_ok     <= 1'b1;
            rx_resend <= 1'b0;
          end
        end else begin
          rx_buf[rx_cnt] <= rx_bit;
          rx_cnt         <= rx_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pl_frame_codec_chk.sv
module pl_frame_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_send,
  input logic tx_busy,
  input logic tx_bit,
  input logic tx_bit_valid,
  input logic tx_bit_ready,
  input logic rx_ok,
  input logic rx_bad,
  input logic rx_resend
);
  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> tx_bit);

  p_hold_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_valid && !tx_bit_ready |=> tx_bit_valid && $stable(tx_bit));

  p_ignore_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && tx_send && !tx_bit_ready |=> tx_busy && $stable(tx_bit));

  p_ok_bad_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ok && rx_bad));

  p_ok_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |=> !rx_ok);

  p_resend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_resend) |-> rx_bad);

  p_resend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_resend) |-> rx_ok);
endmodule

bind pl_frame_codec pl_frame_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_send(tx_send), .tx_busy(tx_busy),
  .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid), .tx_bit_ready(tx_bit_ready),
  .rx_ok(rx_ok), .rx_bad(rx_bad), .rx_resend(rx_resend)
);

// File: tb/pl_frame_codec_tb.sv
module pl_frame_codec_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        tx_send = 1'b0;
  logic [7:0]  tx_node = '0;
  logic        tx_dir = 1'b0, tx_err = 1'b0;
  logic [3:0]  tx_ctrl = '0;
  logic [4:0]  tx_tlm = '0;
  logic [11:0] tx_temp = '0;
  logic        tx_busy, tx_bit, tx_bit_valid;
  logic        tx_bit_ready = 1'b1;
  logic [7:0]  rx_node;
  logic        rx_dir, rx_err;
  logic [3:0]  rx_ctrl;
  logic [4:0]  rx_tlm;
  logic [11:0] rx_temp;
  logic        rx_ok, rx_bad, rx_resend;

  logic loop_mode = 1'b1, stall = 1'b0, inj_bit = 1'b0, inj_valid = 1'b0;
  wire  rx_bit_w   = loop_mode ? tx_bit : inj_bit;
  wire  rx_valid_w = loop_mode ? (tx_bit_valid & tx_bit_ready) : inj_valid;

  pl_frame_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tx_send(tx_send), .tx_node(tx_node), .tx_dir(tx_dir),
    .tx_err(tx_err), .tx_ctrl(tx_ctrl), .tx_tlm(tx_tlm), .tx_temp(tx_temp),
    .tx_busy(tx_busy), .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid),
    .tx_bit_ready(tx_bit_ready), .rx_bit(rx_bit_w), .rx_bit_valid(rx_valid_w),
    .rx_node(rx_node), .rx_dir(rx_dir), .rx_err(rx_err), .rx_ctrl(rx_ctrl),
    .rx_tlm(rx_tlm), .rx_temp(rx_temp), .rx_ok(rx_ok), .rx_bad(rx_bad),
    .rx_resend(rx_resend)
  );

  int checks = 0, fails = 0;
  logic        exp_tx_q[$];
  logic [33:0] exp_rx_q[$];
  logic [30:0] last_good = '0;
  int rdy_cnt = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] build(input logic [30:0] b);
    return {1'b0, 6'($countones(b)), b, 2'b11};
  endfunction

  function automatic logic [30:0] pack(input logic [7:0] node, input logic dir, input logic err,
                                       input logic [3:0] ctrl, input logic [4:0] tlm,
                                       input logic [11:0] temp);
    return {temp, tlm, ctrl, err, node, dir};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    #1;
    tx_bit_ready = stall ? ((rdy_cnt % 3) != 2) : 1'b1;
    rdy_cnt++;
  end

  always @(negedge clk) begin
    logic        eb;
    logic [33:0] e;
    if (rst_n) begin
      if (loop_mode && tx_bit_valid && tx_bit_ready) begin
        if (exp_tx_q.size() == 0) check("R5 unexpected tx bit", 1, 0);
        else begin
          eb = exp_tx_q.pop_front();
          check("R2/R3/R4 tx bit", tx_bit, eb);
        end
      end
      if (rx_ok || rx_bad) begin
        if (exp_rx_q.size() == 0) check("R5/R10 unexpected rx result", 1, 0);
        else begin
          e = exp_rx_q.pop_front();
          check("R7/R8/R9 result kind", {rx_bad, rx_ok}, e[33:32]);
          check("R8/R10 resend flag", rx_resend, e[31]);
          check("R7/R8/R9 parsed fields",
                {rx_temp, rx_tlm, rx_ctrl, rx_err, rx_node, rx_dir}, e[30:0]);
        end
      end
    end
  end

  task automatic load_fields(input logic [30:0] b);
    {tx_temp, tx_tlm, tx_ctrl, tx_err, tx_node, tx_dir} = b;
  endtask

  task automatic queue_frame(input logic [30:0] b);
    logic [39:0] f;
    f = build(b);
    for (int i = 0; i < 40; i++) exp_tx_q.push_back(f[i]);
    exp_rx_q.push_back({2'b01, 1'b0, b});
    last_good = b;
  endtask

  task automatic send(input logic [30:0] b);
    while (tx_busy) tick();
    load_fields(b);
    tx_send = 1'b1;
    queue_frame(b);
    tick();
    tx_send = 1'b0;
    check("R6 busy after accepted strobe", tx_busy, 1);
  endtask

  task automatic send_jam(input logic [30:0] b, input logic [30:0] junk);
    while (tx_busy) tick();
    load_fields(b);
    tx_send = 1'b1;
    queue_frame(b);
    tick();
    load_fields(junk);
    while (tx_busy) tick();
    tx_send = 1'b0;
    check("R5 strobe on final handshake ignored", tx_busy, 0);
    tick();
    check("R5 still idle after jam", tx_busy, 0);
  endtask

  task automatic inject_bit(input logic v, input bit gap);
    inj_bit = v;
    inj_valid = 1'b1;
    tick();
    inj_valid = 1'b0;
    if (gap) tick();
  endtask

  task automatic inject_frame(input logic [39:0] f, input logic [1:0] kind,
                              input logic resend, input logic [30:0] fields);
    exp_rx_q.push_back({kind, resend, fields});
    for (int i = 0; i < 40; i++) inject_bit(f[i], (i % 7) == 3);
    check("R7 result pulse right after last bit", rx_ok | rx_bad, 1);
    tick();
    check("R7 result is one cycle", rx_ok | rx_bad, 0);
  endtask

  initial begin
    logic [39:0] f;
    logic [30:0] b1, b2;
    repeat (3) @(posedge clk);
    #1;
    check("R1 tx_busy in reset", tx_busy, 0);
    check("R1 tx_bit_valid in reset", tx_bit_valid, 0);
    check("R1 rx flags in reset", {rx_ok, rx_bad, rx_resend}, 0);
    check("R1 parsed fields in reset", {rx_temp, rx_tlm, rx_ctrl, rx_err, rx_node, rx_dir}, 0);
    rst_n = 1'b1;
    tick();

    send('0);
    send(31'h7FFF_FFFF);
    stall = 1'b1;
    send(pack(8'hA5, 1'b1, 1'b0, 4'h9, 5'h15, 12'hC3E));
    send_jam(pack(8'h3C, 1'b0, 1'b1, 4'h6, 5'h0A, 12'h5A1), 31'h5555_1234);
    stall = 1'b0;
    for (int k = 0; k < 200 && (exp_tx_q.size() != 0 || exp_rx_q.size() != 0); k++) tick();
    check("R5/R6 loopback scoreboard drained", exp_tx_q.size() + exp_rx_q.size(), 0);

    loop_mode = 1'b0;
    tick();
    b1 = pack(8'h7E, 1'b1, 1'b0, 4'h3, 5'h11, 12'h8F0);
    b2 = pack(8'h02, 1'b0, 1'b1, 4'hC, 5'h1F, 12'h001);

    inject_bit(1'b0, 0); inject_bit(1'b1, 1); inject_bit(1'b0, 0); inject_bit(1'b0, 0);
    check("R10 no pulse while hunting", rx_ok | rx_bad, 0);
    inject_frame(build(b1), 2'b01, 1'b0, b1);
    last_good = b1;

    f = build(b1);
    f[38:33] = f[38:33] + 6'd1;
    inject_frame(f, 2'b10, 1'b1, last_good);
    check("R8 resend held after reject", rx_resend, 1);

    f = build(b2);
    f[39] = 1'b1;
    inject_frame(f, 2'b10, 1'b1, last_good);
    check("R9 resend unchanged by stop error", rx_resend, 1);

    inject_bit(1'b0, 0);
    inject_frame(build(b2), 2'b01, 1'b0, b2);
    check("R10 resend cleared by good frame", rx_resend, 0);

    repeat (5) tick();
    check("R7 rx scoreboard empty", exp_rx_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule